// File: doc/BRIEF.md
# Calendar Real-Time Clock Register Block

This block keeps a wall-clock calendar behind a small 32-bit register interface. One word packs the year, month and day, another packs the weekday, hour, minute and second, and a control word reports which of the two has been rewritten by software since it was last read. A set of scratch words holds values for software. A one-cycle `tick` pulse, once per second, moves the calendar forward. The advance handles month lengths, leap years, and the carry from December into the next year.

Software sets the time by writing the two calendar words. Each such write raises a sticky pending flag. Reading the control word returns both flags and clears them in that same access. A request is accepted on `reqValid && reqReady`. Read data comes back one cycle later, marked by `rspValid`. A build-time parameter picks one of two register maps. Offsets that are unaligned or have no register assigned read as zero, and writes to them are dropped.

Top module: `rtc_calendar_regs`

## Requirements
- R1: An accepted write to the date word stores all 32 bits, and the control word then shows bit 7 set.
- R2: An accepted write to the time word stores all 32 bits, and the control word then shows bit 8 set.
- R3: A read of the control word returns the value held before the access, and it clears bits 7 and 8 so that the next read returns zero. All other control bits always read zero, and writes to the control word have no effect.
- R4: The date word holds the year as an offset from a base year in bits 31:16, the month (1..12) in bits 15:8 and the day (1..31) in bits 7:0. The base year is 2010 for map A and 1970 for map B. The time word holds the weekday in bits 31:29, with 0 for Monday and 6 for Sunday, the hour in 20:16, the minute in 13:8 and the second in 5:0.
- R5: Each `tick` pulse adds one second. Second 59 wraps to 0 and carries into the minute. Minute 59 wraps to 0 and carries into the hour. Hour 23 wraps to 0 and moves the weekday forward, with 6 wrapping to 0.
- R6: A day carry past the last day of the month sets the day to 1 and moves the month forward. The last day is 30 for months 4, 6, 9 and 11, and 31 for the other months except February. February ends on day 29 when the base year plus the offset is divisible by 4, and on day 28 otherwise. A carry past month 12 sets the month to 1 and adds one to the year offset.
- R7: A `tick` in the same cycle as an accepted write to the date word or the time word is discarded. The written value is stored unchanged.
- R8: A read of an unaligned offset, or of an offset with no register, returns zero. A write to such an offset changes no register.
- R9: With map A (`VARIANT`=0), control, date and time sit at 0x00, 0x04 and 0x08, and four scratch words sit at 0x20..0x2C. With map B (`VARIANT`=1), they sit at 0x00, 0x10 and 0x14, and eight scratch words sit at 0x100..0x11C.
- R10: While `rst` is high, the control word and every scratch word clear to zero. The date word loads from `initDate` and the time word from `initTime`.
- R11: A read accepted on one clock edge raises `rspValid` for exactly one cycle after that edge, with the data on `rspRdata`. `reqReady` is low while `rspValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| initDate | input | 32 | Date word value loaded during reset |
| initTime | input | 32 | Time word value loaded during reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset of the word |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 32 | Read data |

## Verification
The calendar and the pending flags are state that only shows up when it is read back. A wrong carry or a wrong month length therefore stays hidden until the time or date word is read after the tick that crosses that boundary. The directed scenarios place the clock one second before each boundary (minute, hour, day, 30-day month, leap and non-leap February, year), apply one tick, and read the word back on the next response. A flag that fails to set or fails to clear shows up on the first or second control-word read after a write. A decode error shows up as nonzero data from an unmapped offset, or as a register changed by an access that should have been dropped.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int DATA_W     = 32;
  localparam int SCR_IDX_W  = 3;
  localparam int DATE_FLAG  = 7;
  localparam int TIME_FLAG  = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_DATE,
    SEL_TIME,
    SEL_SCR
  } regSel_e;

  // strobes from the bus control to the datapath, valid for one cycle
  typedef struct packed {
    logic                 wrDate;
    logic                 wrTime;
    logic                 wrScr;
    logic                 rdCtrl;
    logic                 rdEn;
    regSel_e              sel;
    logic [SCR_IDX_W-1:0] scrIdx;
  } ctrlStrobe_t;

  function automatic logic [7:0] monthDays(input logic [7:0] month, input logic leap);
    case (month)
      8'd2:                      monthDays = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   monthDays = 8'd30;
      default:                   monthDays = 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output ctrlStrobe_t       strb
);

  localparam int NUM_SCR = (VARIANT == 0) ? 4 : 8;
  localparam logic [ADDR_W-1:0] OFF_CTRL = '0;
  localparam logic [ADDR_W-1:0] OFF_DATE = ADDR_W'((VARIANT == 0) ? 'h04 : 'h10);
  localparam logic [ADDR_W-1:0] OFF_TIME = ADDR_W'((VARIANT == 0) ? 'h08 : 'h14);
  localparam logic [ADDR_W-1:0] SCR_BASE = ADDR_W'((VARIANT == 0) ? 'h20 : 'h100);
  localparam logic [ADDR_W-1:0] SCR_END  = ADDR_W'(((VARIANT == 0) ? 'h20 : 'h100) + 4 * NUM_SCR);

  logic              accept;
  regSel_e           sel;
  logic [ADDR_W-1:0] scrOff;

  assign reqReady = ~rspValid;
  assign accept   = reqValid & reqReady;
  assign scrOff   = reqAddr - SCR_BASE;

  always_comb begin
    sel = SEL_NONE;
    if (reqAddr[1:0] == 2'b00) begin
      if (reqAddr == OFF_CTRL)       sel = SEL_CTRL;
      else if (reqAddr == OFF_DATE)  sel = SEL_DATE;
      else if (reqAddr == OFF_TIME)  sel = SEL_TIME;
      else if (reqAddr >= SCR_BASE && reqAddr < SCR_END) sel = SEL_SCR;
    end
  end

  always_comb begin
    strb        = '0;
    strb.sel    = sel;
    strb.scrIdx = scrOff[2 +: SCR_IDX_W];
    if (accept) begin
      strb.wrDate = reqWrite  & (sel == SEL_DATE);
      strb.wrTime = reqWrite  & (sel == SEL_TIME);
      strb.wrScr  = reqWrite  & (sel == SEL_SCR);
      strb.rdCtrl = ~reqWrite & (sel == SEL_CTRL);
      strb.rdEn   = ~reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rspValid <= 1'b0;
    else     rspValid <= accept & ~reqWrite;
  end

endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] initDate,
  input  logic [DATA_W-1:0] initTime,
  input  logic [DATA_W-1:0] wdata,
  input  ctrlStrobe_t       strb,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] dateWord,
  output logic [DATA_W-1:0] timeWord
);

  localparam int NUM_SCR   = (VARIANT == 0) ? 4 : 8;
  localparam int SCR_SEL_W = $clog2(NUM_SCR);
  localparam int BASE_YEAR = (VARIANT == 0) ? 2010 : 1970;
  localparam logic [1:0] BASE_LO = 2'(BASE_YEAR % 4);

  logic                pendDate, pendTime;
  logic [DATA_W-1:0]   scr [NUM_SCR];
  logic                tickEff;

  // calendar fields
  logic [5:0]  sec, mins;
  logic [4:0]  hr;
  logic [2:0]  wd;
  logic [7:0]  day, mon;
  logic [15:0] yr;
  logic [1:0]  yrMod;
  logic        leap, secWrap, minWrap, hrWrap, dayCarry, lastDay, lastMon;
  logic [DATA_W-1:0] nextTime, nextDate;

  assign ctrlWord = {{(DATA_W-9){1'b0}}, pendTime, pendDate, 7'b0};
  assign tickEff  = tick & ~strb.wrDate & ~strb.wrTime;

  always_comb begin
    sec   = timeWord[5:0];
    mins  = timeWord[13:8];
    hr    = timeWord[20:16];
    wd    = timeWord[31:29];
    day   = dateWord[7:0];
    mon   = dateWord[15:8];
    yr    = dateWord[31:16];
    yrMod = BASE_LO + yr[1:0];
    leap  = (yrMod == 2'b00);

    secWrap  = (sec == 6'd59);
    minWrap  = (mins == 6'd59);
    hrWrap   = (hr == 5'd23);
    dayCarry = secWrap & minWrap & hrWrap;
    lastDay  = (day >= monthDays(mon, leap));
    lastMon  = (mon >= 8'd12);

    nextTime = timeWord;
    nextTime[5:0] = secWrap ? 6'd0 : sec + 6'd1;
    if (secWrap)           nextTime[13:8]  = minWrap ? 6'd0 : mins + 6'd1;
    if (secWrap & minWrap) nextTime[20:16] = hrWrap ? 5'd0 : hr + 5'd1;
    if (dayCarry)          nextTime[31:29] = (wd >= 3'd6) ? 3'd0 : wd + 3'd1;

    nextDate = dateWord;
    if (dayCarry) begin
      nextDate[7:0] = lastDay ? 8'd1 : day + 8'd1;
      if (lastDay) begin
        nextDate[15:8] = lastMon ? 8'd1 : mon + 8'd1;
        if (lastMon) nextDate[31:16] = yr + 16'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dateWord <= initDate;
      timeWord <= initTime;
    end else begin
      if (strb.wrDate)  dateWord <= wdata;
      else if (tickEff) dateWord <= nextDate;
      if (strb.wrTime)  timeWord <= wdata;
      else if (tickEff) timeWord <= nextTime;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendDate <= 1'b0;
      pendTime <= 1'b0;
    end else begin
      if (strb.wrDate)      pendDate <= 1'b1;
      else if (strb.rdCtrl) pendDate <= 1'b0;
      if (strb.wrTime)      pendTime <= 1'b1;
      else if (strb.rdCtrl) pendTime <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst) scr[g] <= '0;
      else if (strb.wrScr && strb.scrIdx == SCR_IDX_W'(g)) scr[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (strb.rdEn) begin
      case (strb.sel)
        SEL_CTRL: rdData <= ctrlWord;
        SEL_DATE: rdData <= dateWord;
        SEL_TIME: rdData <= timeWord;
        SEL_SCR:  rdData <= scr[strb.scrIdx[SCR_SEL_W-1:0]];
        default:  rdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
  import rtc_cal_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [31:0]       initDate,
  input  logic [31:0]       initTime,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata
);

  ctrlStrobe_t strb;
  logic [31:0] ctrlWord, dateWord, timeWord;

  rtc_cal_ctrl #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strb     (strb)
  );

  rtc_cal_datapath #(.VARIANT(VARIANT)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .initDate (initDate),
    .initTime (initTime),
    .wdata    (reqWdata),
    .strb     (strb),
    .rdData   (rspRdata),
    .ctrlWord (ctrlWord),
    .dateWord (dateWord),
    .timeWord (timeWord)
  );

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker
  import rtc_cal_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        reqValid,
  input logic        reqReady,
  input logic        reqWrite,
  input logic [31:0] reqWdata,
  input logic        rspValid,
  input logic [31:0] rspRdata,
  input ctrlStrobe_t strb,
  input logic [31:0] ctrlWord,
  input logic [31:0] timeWord,
  input logic [31:0] dateWord
);

  AST_DATE_PENDING: assert property (@(posedge clk) disable iff (rst)
    strb.wrDate |=> (ctrlWord[7] && dateWord == $past(reqWdata))); // R1

  AST_TIME_PENDING: assert property (@(posedge clk) disable iff (rst)
    (strb.wrTime && !tick) |=> (ctrlWord[8] && timeWord == $past(reqWdata))); // R2

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    strb.rdCtrl |=> (ctrlWord[8:7] == 2'b00)); // R3

  AST_CTRL_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (ctrlWord & ~32'h180) == 32'h0); // R3

  AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (rst)
    (strb.wrTime && tick) |=> (timeWord == $past(reqWdata))); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && strb.sel == SEL_NONE) |=> (rspRdata == 32'h0)); // R8

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !reqWrite) |=> rspValid); // R11

  AST_SINGLE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid); // R11

endmodule

bind rtc_calendar_regs rtc_cal_checker i_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqWrite (reqWrite),
  .reqWdata (reqWdata),
  .rspValid (rspValid),
  .rspRdata (rspRdata),
  .strb     (strb),
  .ctrlWord (ctrlWord),
  .timeWord (timeWord),
  .dateWord (dateWord)
);

// File: tb/test_rtc_calendar_regs.sv
`timescale 1ns/1ps
module test_rtc_calendar_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [31:0] initDate, initTime;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr  = '0;
  logic [31:0] reqWdata = '0;
  logic        readyA, readyB, rspValidA, rspValidB;
  logic [31:0] rdataA, rdataB;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  rtc_calendar_regs #(.VARIANT(0), .ADDR_W(12)) i_rtc_calendar_regs (
    .clk(clk), .rst(rst), .tick(tick), .initDate(initDate), .initTime(initTime),
    .reqValid(reqValid), .reqReady(readyA), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValidA), .rspRdata(rdataA));

  rtc_calendar_regs #(.VARIANT(1), .ADDR_W(12)) i_rtc_calendar_regs_b (
    .clk(clk), .rst(rst), .tick(tick), .initDate(initDate), .initTime(initTime),
    .reqValid(reqValid), .reqReady(readyB), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValidB), .rspRdata(rdataB));

  function automatic logic [31:0] mkTime(int w, int h, int m, int s);
    return {3'(w), 8'd0, 5'(h), 2'd0, 6'(m), 2'd0, 6'(s)};
  endfunction

  function automatic logic [31:0] mkDate(int y, int m, int d);
    return {16'(y), 8'(m), 8'(d)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit withTick = 0);
    @(negedge clk);
    while (!readyA) @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d; tick = withTick;
    @(negedge clk);
    reqValid = 0; reqWrite = 0; tick = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] da, output logic [31:0] db);
    @(negedge clk);
    while (!readyA) @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    check("R11 rspValid", {31'd0, rspValidA}, 32'd1);
    da = rdataA; db = rdataB;
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic testReset();
    logic [31:0] a, b;
    rd(12'h004, a, b); check("R10 date preload", a, initDate);
    rd(12'h008, a, b); check("R10 time preload", a, initTime);
    rd(12'h000, a, b); check("R10 ctrl zero", a, 32'h0);
    rd(12'h020, a, b); check("R10 scratch zero", a, 32'h0);
  endtask

  task automatic testHandshake();
    @(negedge clk);
    while (!readyA) @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = 12'h004;
    @(negedge clk);
    reqValid = 0;
    check("R11 valid one cycle after accept", {31'd0, rspValidA}, 32'd1);
    check("R11 ready low with response", {31'd0, readyA}, 32'd0);
    @(negedge clk);
    check("R11 valid drops", {31'd0, rspValidA}, 32'd0);
  endtask

  task automatic testFlags();
    logic [31:0] a, b;
    wr(12'h004, mkDate(5, 7, 9));
    rd(12'h000, a, b); check("R1 date flag", a, 32'h080);
    rd(12'h000, a, b); check("R3 cleared by read", a, 32'h0);
    rd(12'h004, a, b); check("R1 date stored", a, mkDate(5, 7, 9));
    wr(12'h008, mkTime(3, 10, 20, 30));
    rd(12'h000, a, b); check("R2 time flag", a, 32'h100);
    rd(12'h008, a, b); check("R2 time stored", a, mkTime(3, 10, 20, 30));
    wr(12'h004, mkDate(5, 7, 9));
    wr(12'h008, mkTime(3, 10, 20, 30));
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, a, b); check("R3 both flags, ctrl write ignored", a, 32'h180);
    rd(12'h000, a, b); check("R3 both cleared", a, 32'h0);
  endtask

  task automatic tickCase(input string req, input logic [31:0] d0, input logic [31:0] t0,
                          input logic [31:0] d1, input logic [31:0] t1);
    logic [31:0] a, b;
    wr(12'h004, d0);
    wr(12'h008, t0);
    pulseTick();
    rd(12'h008, a, b); check({req, " time"}, a, t1);
    rd(12'h004, a, b); check({req, " date"}, a, d1);
  endtask

  task automatic testTicks();
    tickCase("R5 second", mkDate(1, 3, 3), mkTime(2, 4, 5, 10), mkDate(1, 3, 3), mkTime(2, 4, 5, 11));
    tickCase("R5 hour carry", mkDate(1, 3, 3), mkTime(2, 0, 59, 59), mkDate(1, 3, 3), mkTime(2, 1, 0, 0));
    tickCase("R5 weekday wrap", mkDate(1, 3, 3), mkTime(6, 23, 59, 59), mkDate(1, 3, 4), mkTime(0, 0, 0, 0));
    tickCase("R6 leap Feb 28", mkDate(2, 2, 28), mkTime(1, 23, 59, 59), mkDate(2, 2, 29), mkTime(2, 0, 0, 0));
    tickCase("R6 leap Feb 29", mkDate(2, 2, 29), mkTime(1, 23, 59, 59), mkDate(2, 3, 1), mkTime(2, 0, 0, 0));
    tickCase("R6 common Feb 28", mkDate(3, 2, 28), mkTime(4, 23, 59, 59), mkDate(3, 3, 1), mkTime(5, 0, 0, 0));
    tickCase("R6 April 30", mkDate(3, 4, 30), mkTime(0, 23, 59, 59), mkDate(3, 5, 1), mkTime(1, 0, 0, 0));
    tickCase("R4 R6 year", mkDate(3, 12, 31), mkTime(5, 23, 59, 59), mkDate(4, 1, 1), mkTime(6, 0, 0, 0));
  endtask

  task automatic testWriteVsTick();
    logic [31:0] a, b;
    wr(12'h004, mkDate(2, 2, 28));
    wr(12'h008, mkTime(0, 23, 59, 59), 1);
    rd(12'h008, a, b); check("R7 write wins over tick", a, mkTime(0, 23, 59, 59));
    rd(12'h004, a, b); check("R7 date untouched by dropped tick", a, mkDate(2, 2, 28));
  endtask

  task automatic testUnmapped();
    logic [31:0] a, b;
    wr(12'h004, mkDate(7, 7, 7));
    wr(12'h00C, 32'hDEAD_BEEF);
    rd(12'h00C, a, b); check("R8 unmapped read zero", a, 32'h0);
    wr(12'h005, 32'h1234_5678);
    rd(12'h005, a, b); check("R8 unaligned read zero", a, 32'h0);
    rd(12'h004, a, b); check("R8 unaligned write dropped", a, mkDate(7, 7, 7));
    rd(12'h030, a, b); check("R8 past scratch zero", a, 32'h0);
    check("R8 map B offset 0x30 zero", b, 32'h0);
  endtask

  task automatic testMaps();
    logic [31:0] a, b;
    for (int i = 0; i < 4; i++) wr(12'(12'h020 + 4 * i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 8; i++) wr(12'(12'h100 + 4 * i), 32'hB000_0000 + 32'(i));
    for (int i = 0; i < 4; i++) begin
      rd(12'(12'h020 + 4 * i), a, b);
      check("R9 map A scratch", a, 32'hA000_0000 + 32'(i));
      check("R9 map B ignores A scratch offset", b, 32'h0);
    end
    for (int i = 0; i < 8; i++) begin
      rd(12'(12'h100 + 4 * i), a, b);
      check("R9 map B scratch", b, 32'hB000_0000 + 32'(i));
      check("R9 map A ignores B scratch offset", a, 32'h0);
    end
    wr(12'h010, mkDate(2, 2, 29));
    wr(12'h014, mkTime(1, 23, 59, 59));
    rd(12'h000, a, b); check("R9 map B flags", b, 32'h180);
    pulseTick();
    rd(12'h014, a, b); check("R9 map B time", b, mkTime(2, 0, 0, 0));
    rd(12'h010, a, b); check("R6 map B leap base 1970", b, mkDate(2, 3, 1));
  endtask

  initial begin
    initDate = mkDate(40, 6, 15);
    initTime = mkTime(2, 8, 30, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    testReset();
    testHandshake();
    testFlags();
    testTicks();
    testWriteVsTick();
    testUnmapped();
    testMaps();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule